// File: doc/BRIEF.md
# Commit-Time Way-Selection Controller

This controller sits at the commit end of a fetch pipeline whose target buffer also records which instruction-cache way holds each predicted line. One instruction commits per cycle at most. From the commit outcome it produces three commands for the buffer:

- allocate a fresh entry;
- write the change into the buffer now, because the way is already known;
- park the change in the pending-update queue until the next fetch reports its hit way.

On a misprediction it also produces a way-enable vector for the recovery fetch. When the resolved next address matches one of the stored addresses, only one cache way is powered. All ways are powered when neither stored address matches.

Non-branch instructions can also own buffer entries. They do so only to carry a way prediction for the line that follows. A non-branch that commits with an assigned way-queue pointer and no buffer entry is given one, and its update path follows the same rule as a branch: immediate if the way is known, queued if not.

All commands and the enable vector are registered. They appear one clock after the commit is presented and last for exactly one cycle.

Top module: `wsel_commit_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, every output is 0.
- R2: For a committing branch with a correct prediction that hit in the buffer or was taken:
  - with `cm_way_known` = 1, `o_update` = 1 and `o_defer` = 0 one cycle later;
  - `o_update` and `o_defer` are never both 1.
- R3: For a committing branch that needs a buffer change (it hit or was taken), `o_defer` = 1 and `o_update` = 0 one cycle later when either `cm_way_known` = 0 or the prediction was wrong.
- R4: A committing taken branch with `cm_buf_hit` = 0 raises `o_alloc` one cycle later, and `o_alloc` is only ever raised together with `o_update` or `o_defer`.
- R5: On a branch misprediction with `cm_buf_hit` = 1 and `cm_next_addr` = `cm_tgt_addr`:
  - `o_redirect` = 1 and `o_way_en` has only bit `cm_twp` set;
  - this target match takes priority over a fall-through match.
- R6: On a branch misprediction with `cm_buf_hit` = 1 and `cm_next_addr` = `cm_fall_addr` ≠ `cm_tgt_addr`, `o_redirect` = 1 and `o_way_en` has only bit `cm_fwp` set.
- R7: On a branch misprediction with no address match, or with `cm_buf_hit` = 0, `o_redirect` = 1 and `o_way_en` = all ones.
- R8: For a committing non-branch with `cm_ptr_set` = 1 and `cm_buf_hit` = 0:
  - `o_alloc` = 1 one cycle later;
  - also `o_update` = 1 when `cm_way_known` = 1, and `o_defer` = 1 otherwise;
  - a non-branch never raises `o_redirect`.
- R9: No command is raised by a correctly predicted not-taken branch that missed in the buffer, nor by a non-branch that hit or has `cm_ptr_set` = 0.
- R10: In the cycle after `cm_valid` = 0, every output is 0.
- R11: When `o_redirect` = 0, `o_way_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cm_valid | input | 1 | An instruction commits this cycle |
| cm_is_branch | input | 1 | 1 for a branch, 0 for a non-branch |
| cm_pred_ok | input | 1 | The predicted next address was correct |
| cm_taken | input | 1 | The branch resolved taken |
| cm_buf_hit | input | 1 | The instruction had a buffer entry |
| cm_ptr_set | input | 1 | The instruction holds an assigned way-queue pointer |
| cm_way_known | input | 1 | The way-queue slot at the pointer already holds a way |
| cm_next_addr | input | AW | Resolved next fetch address |
| cm_tgt_addr | input | AW | Stored target address |
| cm_fall_addr | input | AW | Fall-through address |
| cm_twp | input | WIDX | Stored target-line way |
| cm_fwp | input | WIDX | Stored fall-through-line way |
| o_alloc | output | 1 | Allocate a buffer entry |
| o_update | output | 1 | Write the buffer change now |
| o_defer | output | 1 | Push the change onto the pending-update queue |
| o_redirect | output | 1 | A recovery fetch enable is issued |
| o_way_en | output | WAYS | Cache way enables for the recovery fetch |

## Verification
The bench builds the block with its defaults: `AW` = 32 and `WAYS` = 4, so `WIDX` = 2. Random addresses are drawn from a pool of four values. This makes target, fall-through and double matches frequent, which keeps the priority and all-ways corners in reach. Because the 2-bit way indices cover every way of the 4-bit enable vector, each one-hot position of `o_way_en` is reached by the random phase.

// File: rtl/wsel_pkg.sv
package wsel_pkg;

    // Which stored way, if any, drives the recovery fetch enable
    typedef enum logic [1:0] {
        STEER_NONE = 2'd0,
        STEER_TGT  = 2'd1,
        STEER_FALL = 2'd2,
        STEER_ALL  = 2'd3
    } steer_e;

    typedef struct packed {
        logic alloc;
        logic update;
        logic defer;
        logic redirect;
    } cmd_t;

    localparam cmd_t CMD_IDLE = '{alloc: 1'b0, update: 1'b0, defer: 1'b0, redirect: 1'b0};

    // Pick the immediate or queued write path for a needed change
    function automatic cmd_t write_path(input logic need, input logic known);
        cmd_t c;
        c        = CMD_IDLE;
        c.update = need & known;
        c.defer  = need & ~known;
        return c;
    endfunction

endpackage

// File: rtl/cmt_addr_match.sv
module cmt_addr_match #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    output logic          eq
);
    always_comb eq = (a == b);
endmodule

// File: rtl/cmt_upd_ctrl.sv
module cmt_upd_ctrl
    import wsel_pkg::*;
(
    input  logic   valid,
    input  logic   is_branch,
    input  logic   pred_ok,
    input  logic   taken,
    input  logic   buf_hit,
    input  logic   ptr_set,
    input  logic   way_known,
    input  logic   hit_tgt,
    input  logic   hit_fall,
    output cmd_t   cmd,
    output steer_e steer
);
    logic need_chg;

    always_comb begin
        cmd      = CMD_IDLE;
        steer    = STEER_NONE;
        need_chg = 1'b0;
        if (valid) begin
            if (is_branch) begin
                need_chg  = buf_hit | taken;
                // A wrong prediction never knows the recovery line's way yet
                cmd       = write_path(need_chg, way_known & pred_ok);
                cmd.alloc = taken & ~buf_hit;
                if (!pred_ok) begin
                    cmd.redirect = 1'b1;
                    if (buf_hit && hit_tgt)       steer = STEER_TGT;
                    else if (buf_hit && hit_fall) steer = STEER_FALL;
                    else                          steer = STEER_ALL;
                end
            end else begin
                need_chg  = ptr_set & ~buf_hit;
                cmd       = write_path(need_chg, way_known);
                cmd.alloc = need_chg;
            end
        end
    end
endmodule

// File: rtl/cmt_way_steer.sv
module cmt_way_steer
    import wsel_pkg::*;
#(
    parameter int WAYS = 4,
    localparam int WIDX = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  steer_e          steer,
    input  logic [WIDX-1:0] twp,
    input  logic [WIDX-1:0] fwp,
    output logic [WAYS-1:0] en
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        always_comb begin
            en[w] = (steer == STEER_ALL)
                  | ((steer == STEER_TGT)  && (twp == WIDX'(w)))
                  | ((steer == STEER_FALL) && (fwp == WIDX'(w)));
        end
    end
endmodule

// File: rtl/wsel_commit_ctrl.sv
module wsel_commit_ctrl
    import wsel_pkg::*;
#(
    parameter int AW   = 32,
    parameter int WAYS = 4,
    localparam int WIDX = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cm_valid,
    input  logic            cm_is_branch,
    input  logic            cm_pred_ok,
    input  logic            cm_taken,
    input  logic            cm_buf_hit,
    input  logic            cm_ptr_set,
    input  logic            cm_way_known,
    input  logic [AW-1:0]   cm_next_addr,
    input  logic [AW-1:0]   cm_tgt_addr,
    input  logic [AW-1:0]   cm_fall_addr,
    input  logic [WIDX-1:0] cm_twp,
    input  logic [WIDX-1:0] cm_fwp,
    output logic            o_alloc,
    output logic            o_update,
    output logic            o_defer,
    output logic            o_redirect,
    output logic [WAYS-1:0] o_way_en
);
    logic            hit_tgt, hit_fall;
    cmd_t            cmd_d, cmd_q;
    steer_e          steer_d;
    logic [WAYS-1:0] en_d, en_q;

    cmt_addr_match #(.AW(AW)) u_m_tgt (
        .a(cm_next_addr), .b(cm_tgt_addr), .eq(hit_tgt)
    );
    cmt_addr_match #(.AW(AW)) u_m_fall (
        .a(cm_next_addr), .b(cm_fall_addr), .eq(hit_fall)
    );

    cmt_upd_ctrl u_ctrl (
        .valid(cm_valid), .is_branch(cm_is_branch), .pred_ok(cm_pred_ok),
        .taken(cm_taken), .buf_hit(cm_buf_hit), .ptr_set(cm_ptr_set),
        .way_known(cm_way_known), .hit_tgt(hit_tgt), .hit_fall(hit_fall),
        .cmd(cmd_d), .steer(steer_d)
    );

    cmt_way_steer #(.WAYS(WAYS)) u_steer (
        .steer(steer_d), .twp(cm_twp), .fwp(cm_fwp), .en(en_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= CMD_IDLE;
            en_q  <= '0;
        end else begin
            cmd_q <= cmd_d;
            en_q  <= en_d;
        end
    end

    assign o_alloc    = cmd_q.alloc;
    assign o_update   = cmd_q.update;
    assign o_defer    = cmd_q.defer;
    assign o_redirect = cmd_q.redirect;
    assign o_way_en   = en_q;
endmodule

// File: rtl/wsel_commit_chk.sv
module wsel_commit_chk #(
    parameter int AW   = 32,
    parameter int WAYS = 4,
    localparam int WIDX = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input logic            clk,
    input logic            rst,
    input logic            cm_valid,
    input logic            cm_is_branch,
    input logic            cm_pred_ok,
    input logic            cm_buf_hit,
    input logic [AW-1:0]   cm_next_addr,
    input logic [AW-1:0]   cm_tgt_addr,
    input logic [WIDX-1:0] cm_twp,
    input logic            o_alloc,
    input logic            o_update,
    input logic            o_defer,
    input logic            o_redirect,
    input logic [WAYS-1:0] o_way_en
);
    // R2
    upd_defer_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(o_update && o_defer));

    // R4
    alloc_has_path_chk: assert property (@(posedge clk) disable iff (rst)
        o_alloc |-> (o_update || o_defer));

    // R5
    tgt_steer_chk: assert property (@(posedge clk) disable iff (rst)
        (cm_valid && cm_is_branch && !cm_pred_ok && cm_buf_hit && cm_next_addr == cm_tgt_addr)
        |=> (o_redirect && o_way_en == (WAYS'(1) << $past(cm_twp))));

    // R7
    en_shape_chk: assert property (@(posedge clk) disable iff (rst)
        o_redirect |-> ($countones(o_way_en) == 1 || o_way_en == '1));

    // R11
    quiet_en_chk: assert property (@(posedge clk) disable iff (rst)
        !o_redirect |-> (o_way_en == '0));

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cm_valid |=> !(o_alloc || o_update || o_defer || o_redirect));
endmodule

bind wsel_commit_ctrl wsel_commit_chk #(.AW(AW), .WAYS(WAYS)) u_chk (
    .clk(clk), .rst(rst), .cm_valid(cm_valid), .cm_is_branch(cm_is_branch),
    .cm_pred_ok(cm_pred_ok), .cm_buf_hit(cm_buf_hit), .cm_next_addr(cm_next_addr),
    .cm_tgt_addr(cm_tgt_addr), .cm_twp(cm_twp), .o_alloc(o_alloc),
    .o_update(o_update), .o_defer(o_defer), .o_redirect(o_redirect),
    .o_way_en(o_way_en)
);

// File: tb/tb_wsel_commit_ctrl.sv
module tb_wsel_commit_ctrl;
    localparam int AW = 32;
    localparam int WAYS = 4;
    localparam int WIDX = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic v, br, ok, tk, hit, ps, wk;
    logic [AW-1:0] na, ta, fa;
    logic [WIDX-1:0] tw, fw;
    logic o_alloc, o_update, o_defer, o_redirect;
    logic [WAYS-1:0] o_way_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wsel_commit_ctrl #(.AW(AW), .WAYS(WAYS)) dut (
        .clk(clk), .rst(rst), .cm_valid(v), .cm_is_branch(br), .cm_pred_ok(ok),
        .cm_taken(tk), .cm_buf_hit(hit), .cm_ptr_set(ps), .cm_way_known(wk),
        .cm_next_addr(na), .cm_tgt_addr(ta), .cm_fall_addr(fa),
        .cm_twp(tw), .cm_fwp(fw), .o_alloc(o_alloc), .o_update(o_update),
        .o_defer(o_defer), .o_redirect(o_redirect), .o_way_en(o_way_en)
    );

    // Expected {alloc, update, defer, redirect, way_en[3:0]} from the requirements
    function automatic logic [7:0] expect_out();
        logic a = 0, u = 0, d = 0, r = 0;
        logic [3:0] e = 4'b0;
        if (v) begin
            if (br) begin
                if (hit || tk) begin
                    if (ok && wk) u = 1; else d = 1;
                end
                if (tk && !hit) a = 1;
                if (!ok) begin
                    r = 1;
                    if (hit && na == ta)      e = 4'b1 << tw;
                    else if (hit && na == fa) e = 4'b1 << fw;
                    else                      e = 4'b1111;
                end
            end else if (ps && !hit) begin
                a = 1;
                if (wk) u = 1; else d = 1;
            end
        end
        return {a, u, d, r, e};
    endfunction

    function automatic string tag_of();
        if (!v) return "R10";
        if (br) begin
            if (!ok && hit && na == ta) return "R5";
            if (!ok && hit && na == fa) return "R6";
            if (!ok) return "R7";
            if (tk && !hit) return "R4";
            if (hit && wk) return "R2";
            if (hit) return "R3";
            return "R9";
        end
        if (ps && !hit) return "R8";
        return "R9";
    endfunction

    task automatic put(input logic iv, input logic ib, input logic iok, input logic itk,
                       input logic ih, input logic ips, input logic iwk,
                       input logic [AW-1:0] ina, input logic [AW-1:0] ita,
                       input logic [AW-1:0] ifa, input logic [WIDX-1:0] itw,
                       input logic [WIDX-1:0] ifw);
        v = iv; br = ib; ok = iok; tk = itk; hit = ih; ps = ips; wk = iwk;
        na = ina; ta = ita; fa = ifa; tw = itw; fw = ifw;
    endtask

    // Inputs set at a falling edge are captured at the next rising edge;
    // the registered result is sampled at the falling edge after that.
    task automatic step_check();
        logic [7:0] exp_v;
        string t;
        exp_v = expect_out();
        t = tag_of();
        @(negedge clk);
        n_chk++;
        if ({o_alloc, o_update, o_defer, o_redirect, o_way_en} !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", t,
                     {o_alloc, o_update, o_defer, o_redirect, o_way_en}, exp_v);
        end
        // R11: enable is quiet whenever no redirect is issued
        if (!o_redirect) begin
            n_chk++;
            if (o_way_en !== 4'b0) begin
                n_bad++;
                $display("FAIL R11: got %b expected 0000", o_way_en);
            end
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] pool [4];
        void'($urandom(32'h5eed_1234));
        pool[0] = 32'h0000_1000; pool[1] = 32'h0000_1020;
        pool[2] = 32'h0000_2040; pool[3] = 32'h0000_3000;

        // R1: reset state, active inputs must not leak out
        put(1, 1, 0, 1, 0, 1, 1, pool[0], pool[0], pool[1], 2'd1, 2'd2);
        @(negedge clk); @(negedge clk);
        n_chk++;
        if ({o_alloc, o_update, o_defer, o_redirect, o_way_en} !== 8'b0) begin
            n_bad++;
            $display("FAIL R1: got %b expected 00000000",
                     {o_alloc, o_update, o_defer, o_redirect, o_way_en});
        end
        rst = 1'b0;
        put(0, 0, 0, 0, 0, 0, 0, pool[0], pool[1], pool[2], 2'd0, 2'd0);
        @(negedge clk);
        // R1: first cycle after release still reflects reset
        n_chk++;
        if ({o_alloc, o_update, o_defer, o_redirect, o_way_en} !== 8'b0) begin
            n_bad++;
            $display("FAIL R1: got %b expected 00000000",
                     {o_alloc, o_update, o_defer, o_redirect, o_way_en});
        end

        // Directed corners
        put(1, 1, 1, 1, 1, 1, 1, pool[0], pool[0], pool[1], 2'd0, 2'd1); step_check(); // R2
        put(1, 1, 1, 0, 1, 1, 0, pool[1], pool[0], pool[1], 2'd0, 2'd1); step_check(); // R3
        put(1, 1, 1, 1, 0, 1, 1, pool[0], pool[0], pool[1], 2'd0, 2'd1); step_check(); // R4
        put(1, 1, 0, 1, 1, 1, 1, pool[2], pool[2], pool[3], 2'd3, 2'd1); step_check(); // R5
        put(1, 1, 0, 0, 1, 1, 1, pool[1], pool[1], pool[1], 2'd2, 2'd0); step_check(); // R5 priority
        put(1, 1, 0, 0, 1, 1, 1, pool[3], pool[2], pool[3], 2'd3, 2'd1); step_check(); // R6
        put(1, 1, 0, 1, 1, 1, 1, pool[0], pool[2], pool[3], 2'd3, 2'd1); step_check(); // R7
        put(1, 1, 0, 1, 0, 1, 1, pool[2], pool[2], pool[3], 2'd3, 2'd1); step_check(); // R7 miss
        put(1, 0, 1, 0, 0, 1, 1, pool[1], pool[0], pool[1], 2'd0, 2'd2); step_check(); // R8
        put(1, 0, 1, 0, 0, 1, 0, pool[1], pool[0], pool[1], 2'd0, 2'd2); step_check(); // R8
        put(1, 0, 1, 0, 1, 1, 1, pool[1], pool[0], pool[1], 2'd0, 2'd2); step_check(); // R9
        put(1, 0, 1, 0, 0, 0, 1, pool[1], pool[0], pool[1], 2'd0, 2'd2); step_check(); // R9
        put(1, 1, 1, 0, 0, 1, 1, pool[1], pool[0], pool[1], 2'd0, 2'd2); step_check(); // R9
        put(0, 1, 0, 1, 0, 1, 1, pool[0], pool[0], pool[1], 2'd0, 2'd2); step_check(); // R10

        // Constrained random phase
        for (int i = 0; i < 600; i++) begin
            put(($urandom % 8) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
                $urandom % 2, $urandom % 2, $urandom % 2,
                pool[$urandom % 4], pool[$urandom % 4], pool[$urandom % 4],
                WIDX'($urandom % 4), WIDX'($urandom % 4));
            step_check();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule